// File: doc/BRIEF.md
# Cross-Clock Command Mailbox Pair

This block gives two independently clocked ports, A and B, a pair of single-word command registers that bypass the main data queue. One register carries words from A to B and the other carries words from B to A. Each register has a flag in the writer's clock domain that is active-low when full. The writer may load the register only while its flag is high. Loading the register pulls the flag low. When the opposite port reads the word, the flag returns high once that event has crossed back into the writer's domain.

Each port's output bus is a multiplexer. It presents the inbound mailbox when the port's mailbox-select input is high, and the queue's output register when that input is low. A static bus-size setting narrows the usable mailbox width to 18 or 9 bits. Input bits above the usable width are discarded, and output bits above it are driven to zero. Flag events cross between the domains as toggles through two-flop synchronizers. The reader also gets a pending indication in its own domain.

Top module: `mbx_bypass_top`

## Requirements
- R1: After reset both full flags (`ab_full_n`, `ba_full_n`) are high, both pending outputs are low, and both mail registers read as zero.
- R2: A write strobe with that port's mailbox select high, while the port's full flag is high, loads the outbound mail register on that port's rising clock edge. The port's full flag is low after that edge.
- R3: A mailbox write attempted while the full flag is low is ignored, and the register keeps its earlier word.
- R4: A read strobe with mailbox select high, while the port's inbound pending output is high, drops that pending output at the same rising edge. The writer's full flag returns high within three writer-clock edges after that.
- R5: Reading a mail register leaves its contents unchanged. A later output of the same register shows the same word until a new write occurs.
- R6: Write or read strobes with mailbox select low have no effect on flags, pending outputs or mail contents.
- R7: A port's output shows its inbound mail register when mailbox select is high. When mailbox select is low, it shows all 36 bits of that port's queue output input.
- R8: The bus-size encoding is 2'b00 = 36 bits, 2'b01 = 18 bits (bits 17:0), 2'b10 = 9 bits (bits 8:0), and 2'b11 = 36 bits. Input bits above the usable width are not stored. Mailbox output bits above it read as zero. There is no byte reordering.
- R9: The reader's pending output rises within three reader-clock edges after the writer's loading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A reset, asynchronous, active low |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B reset, asynchronous, active low |
| bus_size | input | 2 | Static usable-width select (see R8) |
| a_wr | input | 1 | Port A write strobe |
| a_rd | input | 1 | Port A read strobe |
| a_mb_sel | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Queue output register seen by port A |
| a_dout | output | 36 | Port A output bus |
| b_wr | input | 1 | Port B write strobe |
| b_rd | input | 1 | Port B read strobe |
| b_mb_sel | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Queue output register seen by port B |
| b_dout | output | 36 | Port B output bus |
| ab_full_n | output | 1 | A-to-B register full flag, active low, clk_a domain |
| ab_pending | output | 1 | Unread A-to-B word, clk_b domain |
| ba_full_n | output | 1 | B-to-A register full flag, active low, clk_b domain |
| ba_pending | output | 1 | Unread B-to-A word, clk_a domain |

## Verification
The assertions assume that `bus_size` stays constant while either mailbox holds an unread word. They also assume that each port's strobes and mailbox select are synchronous to that port's own clock. Both resets are taken to be asserted together at start-up. The bench changes `bus_size` only between vectors, when both mailboxes are idle. It drives every port input at the falling edge of that port's clock and waits long enough for each handshake to settle before the next step.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W = 36;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned BYTE_W = WORD_W / 4;

  typedef enum logic [1:0] {
    BUS_W36  = 2'b00,
    BUS_W18  = 2'b01,
    BUS_W9   = 2'b10,
    BUS_WALT = 2'b11
  } bus_size_e;

  // Usable-lane mask for a given bus-size code.
  function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] sz);
    logic [WORD_W-1:0] m;
    case (bus_size_e'(sz))
      BUS_W18: m = {{(WORD_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      BUS_W9:  m = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
      default: m = {WORD_W{1'b1}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic [1:0]        bus_size,
  input  logic              wr_req,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_req,
  output logic              full_n,
  output logic              pending,
  output logic [WORD_W-1:0] mail,
  output logic              load_evt,
  output logic              take_evt
);
  logic              req_tog;
  logic              ack_tog;
  logic              req_seen_r;
  logic              ack_seen_w;
  logic [WORD_W-1:0] mail_q;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(rclk), .rst_n(rrst_n), .d(req_tog), .q(req_seen_r)
  );

  mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(wclk), .rst_n(wrst_n), .d(ack_tog), .q(ack_seen_w)
  );

  // Writer side: free while every request toggle has been acknowledged.
  assign full_n   = (req_tog == ack_seen_w);
  assign load_evt = wr_req && full_n;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      mail_q  <= '0;
      req_tog <= 1'b0;
    end else if (load_evt) begin
      mail_q  <= wdata & lane_mask(bus_size);
      req_tog <= ~req_tog;
    end
  end

  // Reader side: a word is pending while the request has not been answered.
  assign pending  = (req_seen_r != ack_tog);
  assign take_evt = rd_req && pending;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)       ack_tog <= 1'b0;
    else if (take_evt) ack_tog <= ~ack_tog;
  end

  assign mail = mail_q;
endmodule

// File: rtl/mbx_port_out.sv
module mbx_port_out
  import mbx_pkg::*;
(
  input  logic              mb_sel,
  input  logic [1:0]        bus_size,
  input  logic [WORD_W-1:0] mail,
  input  logic [WORD_W-1:0] fifo_q,
  output logic [WORD_W-1:0] dout
);
  always_comb begin
    if (mb_sel) dout = mail & lane_mask(bus_size);
    else        dout = fifo_q;
  end
endmodule

// File: rtl/mbx_bypass_top.sv
module mbx_bypass_top
  import mbx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic [1:0]        bus_size,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic              a_mb_sel,
  input  logic [WORD_W-1:0] a_din,
  input  logic [WORD_W-1:0] a_fifo_q,
  output logic [WORD_W-1:0] a_dout,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic              b_mb_sel,
  input  logic [WORD_W-1:0] b_din,
  input  logic [WORD_W-1:0] b_fifo_q,
  output logic [WORD_W-1:0] b_dout,
  output logic              ab_full_n,
  output logic              ab_pending,
  output logic              ba_full_n,
  output logic              ba_pending
);
  // Named internal events, brought out for the checker.
  logic              ab_load, ab_take, ba_load, ba_take;
  logic [WORD_W-1:0] ab_mail, ba_mail;

  mbx_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ab (
    .wclk(clk_a), .wrst_n(rst_a_n), .bus_size(bus_size),
    .wr_req(a_wr && a_mb_sel), .wdata(a_din),
    .rclk(clk_b), .rrst_n(rst_b_n), .rd_req(b_rd && b_mb_sel),
    .full_n(ab_full_n), .pending(ab_pending), .mail(ab_mail),
    .load_evt(ab_load), .take_evt(ab_take)
  );

  mbx_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ba (
    .wclk(clk_b), .wrst_n(rst_b_n), .bus_size(bus_size),
    .wr_req(b_wr && b_mb_sel), .wdata(b_din),
    .rclk(clk_a), .rrst_n(rst_a_n), .rd_req(a_rd && a_mb_sel),
    .full_n(ba_full_n), .pending(ba_pending), .mail(ba_mail),
    .load_evt(ba_load), .take_evt(ba_take)
  );

  mbx_port_out u_out_a (
    .mb_sel(a_mb_sel), .bus_size(bus_size), .mail(ba_mail),
    .fifo_q(a_fifo_q), .dout(a_dout)
  );

  mbx_port_out u_out_b (
    .mb_sel(b_mb_sel), .bus_size(bus_size), .mail(ab_mail),
    .fifo_q(b_fifo_q), .dout(b_dout)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
(
  input logic              clk_a,
  input logic              rst_a_n,
  input logic              clk_b,
  input logic              rst_b_n,
  input logic [1:0]        bus_size,
  input logic              a_mb_sel,
  input logic              b_mb_sel,
  input logic [WORD_W-1:0] a_dout,
  input logic [WORD_W-1:0] b_dout,
  input logic [WORD_W-1:0] a_fifo_q,
  input logic              ab_full_n,
  input logic              ab_pending,
  input logic              ba_full_n,
  input logic              ba_pending,
  input logic              ab_load,
  input logic              ab_take,
  input logic              ba_load,
  input logic              ba_take,
  input logic [WORD_W-1:0] ab_mail,
  input logic [WORD_W-1:0] ba_mail
);
  assert_ab_load_clears_R2: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    ab_load |=> !ab_full_n);
  assert_ba_load_clears_R2: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    ba_load |=> !ba_full_n);

  assert_ab_full_holds_R3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !ab_full_n |=> $stable(ab_mail));
  assert_ba_full_holds_R3: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !ba_full_n |=> $stable(ba_mail));

  assert_ab_take_drops_R4: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    ab_take |=> !ab_pending);
  assert_ba_take_drops_R4: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    ba_take |=> !ba_pending);

  assert_ab_idle_keeps_R5: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !ab_load |=> $stable(ab_mail));

  assert_a_fifo_path_R7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !a_mb_sel |-> (a_dout == a_fifo_q));

  assert_b_upper9_zero_R8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_mb_sel && bus_size == 2'b10) |-> (b_dout[WORD_W-1:BYTE_W] == '0));
  assert_a_upper18_zero_R8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_mb_sel && bus_size == 2'b01) |-> (a_dout[WORD_W-1:HALF_W] == '0));
endmodule

bind mbx_bypass_top mbx_checker u_chk (
  .clk_a, .rst_a_n, .clk_b, .rst_b_n, .bus_size,
  .a_mb_sel, .b_mb_sel, .a_dout, .b_dout, .a_fifo_q,
  .ab_full_n, .ab_pending, .ba_full_n, .ba_pending,
  .ab_load, .ab_take, .ba_load, .ba_take, .ab_mail, .ba_mail
);

// File: tb/mbx_bypass_top_bench.sv
module mbx_bypass_top_bench;
  logic        clk_a = 1'b0, clk_b = 1'b0;
  logic        rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic [1:0]  bus_size = 2'b00;
  logic        a_wr = 1'b0, a_rd = 1'b0, a_mb_sel = 1'b1;
  logic        b_wr = 1'b0, b_rd = 1'b0, b_mb_sel = 1'b1;
  logic [35:0] a_din = '0, b_din = '0, a_fifo_q = '0, b_fifo_q = '0;
  logic [35:0] a_dout, b_dout;
  logic        ab_full_n, ab_pending, ba_full_n, ba_pending;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_a = ~clk_a;   // 50 MHz
  always #13 clk_b = ~clk_b;

  mbx_bypass_top u_mbx_bypass_top (.*);

  // {bus_size, word}
  localparam int NVEC = 8;
  localparam logic [37:0] VEC [NVEC] = '{
    {2'b00, 36'hF_1234_5678},
    {2'b00, 36'h0_0000_0001},
    {2'b01, 36'hA_BCDE_F012},
    {2'b01, 36'h5_5555_5555},
    {2'b10, 36'hF_FFFF_FFFF},
    {2'b10, 36'h3_0000_0155},
    {2'b11, 36'h9_8765_4321},
    {2'b11, 36'h0_FFFF_0000}
  };

  function automatic logic [35:0] usable(input logic [1:0] sz, input logic [35:0] d);
    if (sz == 2'b01) return {18'd0, d[17:0]};
    if (sz == 2'b10) return {27'd0, d[8:0]};
    return d;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input bit wr, input bit rd, input bit sel, input logic [35:0] d);
    @(negedge clk_a);
    a_wr = wr; a_rd = rd; a_mb_sel = sel; a_din = d;
    @(negedge clk_a);
    a_wr = 1'b0; a_rd = 1'b0; a_mb_sel = 1'b1;
  endtask

  task automatic b_op(input bit wr, input bit rd, input bit sel, input logic [35:0] d);
    @(negedge clk_b);
    b_wr = wr; b_rd = rd; b_mb_sel = sel; b_din = d;
    @(negedge clk_b);
    b_wr = 1'b0; b_rd = 1'b0; b_mb_sel = 1'b1;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_a);
    repeat (5) @(negedge clk_b);
  endtask

  initial begin
    repeat (100000) @(posedge clk_a);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [35:0] w;
    repeat (3) @(negedge clk_a);
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    @(negedge clk_b); @(negedge clk_a);

    // R1: reset state
    chk("R1 ab_full_n", 36'(ab_full_n), 36'd1);
    chk("R1 ba_full_n", 36'(ba_full_n), 36'd1);
    chk("R1 ab_pending", 36'(ab_pending), 36'd0);
    chk("R1 ba_pending", 36'(ba_pending), 36'd0);
    chk("R1 a_dout mail", a_dout, 36'd0);
    chk("R1 b_dout mail", b_dout, 36'd0);

    // Vector walk, both directions
    for (int i = 0; i < NVEC; i++) begin
      bus_size = VEC[i][37:36];
      w = VEC[i][35:0];
      a_op(1, 0, 1, w);
      chk("R2 ab_full_n low after write", 36'(ab_full_n), 36'd0);
      repeat (3) @(negedge clk_b);
      chk("R9 ab_pending raised", 36'(ab_pending), 36'd1);
      chk("R8 b_dout masked mail", b_dout, usable(bus_size, w));
      b_op(0, 1, 1, '0);
      chk("R4 ab_pending dropped", 36'(ab_pending), 36'd0);
      repeat (3) @(negedge clk_a);
      chk("R4 ab_full_n restored", 36'(ab_full_n), 36'd1);

      b_op(1, 0, 1, ~w);
      chk("R2 ba_full_n low after write", 36'(ba_full_n), 36'd0);
      repeat (3) @(negedge clk_a);
      chk("R9 ba_pending raised", 36'(ba_pending), 36'd1);
      chk("R8 a_dout masked mail", a_dout, usable(bus_size, ~w));
      a_op(0, 1, 1, '0);
      chk("R4 ba_pending dropped", 36'(ba_pending), 36'd0);
      repeat (3) @(negedge clk_b);
      chk("R4 ba_full_n restored", 36'(ba_full_n), 36'd1);
      settle();
    end

    bus_size = 2'b00;
    // R3: second write while full is ignored
    a_op(1, 0, 1, 36'h1_1111_1111);
    a_op(1, 0, 1, 36'h2_2222_2222);
    settle();
    chk("R3 ab mail kept", b_dout, 36'h1_1111_1111);
    chk("R3 ab_full_n still low", 36'(ab_full_n), 36'd0);
    b_op(0, 1, 1, '0);
    settle();

    // R5: contents survive the read, extra read does nothing
    chk("R5 b_dout after read", b_dout, 36'h1_1111_1111);
    b_op(0, 1, 1, '0);
    settle();
    chk("R5 b_dout after idle read", b_dout, 36'h1_1111_1111);
    chk("R5 ab_full_n stays high", 36'(ab_full_n), 36'd1);

    // R6: strobes with select low have no mailbox effect
    a_op(1, 0, 0, 36'h7_7777_7777);
    settle();
    chk("R6 ab_full_n untouched", 36'(ab_full_n), 36'd1);
    chk("R6 ab_pending untouched", 36'(ab_pending), 36'd0);
    chk("R6 ab mail untouched", b_dout, 36'h1_1111_1111);
    b_op(1, 0, 1, 36'h4_4444_4444);
    settle();
    a_op(0, 1, 0, '0);
    settle();
    chk("R6 ba_pending kept", 36'(ba_pending), 36'd1);
    chk("R6 ba_full_n kept low", 36'(ba_full_n), 36'd0);
    a_op(0, 1, 1, '0);
    settle();

    // R7: select low passes the queue output at full width
    a_fifo_q = 36'hC_AFE0_BEEF; b_fifo_q = 36'h8_0000_0001;
    bus_size = 2'b10;
    @(negedge clk_a); a_mb_sel = 1'b0;
    @(negedge clk_b); b_mb_sel = 1'b0;
    @(negedge clk_a);
    chk("R7 a_dout queue path", a_dout, 36'hC_AFE0_BEEF);
    chk("R7 b_dout queue path", b_dout, 36'h8_0000_0001);
    a_mb_sel = 1'b1;
    @(negedge clk_b); b_mb_sel = 1'b1;
    @(negedge clk_a);
    chk("R7 a_dout mail path", a_dout, usable(2'b10, 36'h4_4444_4444));
    chk("R8 b_dout 9-bit lanes", b_dout, usable(2'b10, 36'h1_1111_1111));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule